// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block holds a small bank of free-running event counters that software reaches through a simple 32-bit register bus. Each counter watches one line of a 32-bit vector of single-cycle hardware event strobes. While its counter is running, it adds one in every cycle in which that line is high.

A counter is selected and enabled by one 5-bit event code. A non-zero code picks strobe line `code` and starts counting. A code of zero stops the counter. There is no separate enable bit.

An elaboration parameter chooses one of two register arrangements:

- **Tile arrangement:** each counter has its own control word, and its data word sits next to it.
- **Channel arrangement:** a single shared control word carries one byte per counter, and the data words are spaced further apart.

Software can read any data register to get the live count. Software can also overwrite a data register, normally with zero, to restart a measurement. The counters wrap silently. Software is expected to poll often enough to unfold the wraps.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset, every control field and every counter is zero, so every mapped register reads zero.
- R2: A counter with non-zero code c adds one at each clock edge where strobe bit c of `evt_strobe` is high, using the code held before that edge.
- R3: A counter whose code is zero holds its value whatever the strobes do.
- R4: A counter at 0xFFFFFFFF that counts once becomes 0x00000000 and carries on from there, with no other effect.
- R5: In the tile arrangement (LAYOUT = LAYOUT_TILE), counter n has:
  - its control word at byte address 0xA8 + 8·n, with its code in bits [7:3];
  - its data word at 0xAC + 8·n.
- R6: In the channel arrangement (LAYOUT = LAYOUT_CHAN), all counters share one control word at 0x234:
  - counter n's code occupies bits [8·n+5 : 8·n+1];
  - one write updates every counter's field at once;
  - counter n's data word is at 0x240 + 0xC·n.
- R7: A bus write to a data register loads the written value at that edge, and it wins over a strobe that would increment the counter in the same cycle.
- R8: A code at or above the arrangement's limit is discarded and that counter keeps its previous code. The limit is 0x18 for tile and 0x10 for channel. In the channel arrangement only the offending byte is discarded.
- R9: Control bits outside the code fields read as zero. Addresses that map to no register read as zero, and writes to them change nothing.
- R10: A read strobe at one edge places the addressed value, as it stood before that edge, on `bus_rdata` after the edge. The output holds its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register accessed |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| evt_strobe | input | 32 | Hardware event strobes, one per code value |

## Verification
Everything observable lands exactly one edge after its stimulus:

- a written code or count is in place after the edge that sampled the write;
- an increment shows after the edge that sampled the strobe;
- read data appears after the edge that sampled the read strobe, carrying the state from before that edge.

The bench drives each stimulus at the falling edge and computes its expected read value from its model before applying that edge. It then advances the model and samples `bus_rdata` one time unit after the rising edge. This keeps every comparison aligned with that single register stage. A tile-arrangement and a channel-arrangement instance share one bus, so each access also tests that the other arrangement ignores it.

// File: rtl/evb_pkg.sv
package evb_pkg;
   localparam int CODE_W = 5;
   localparam int NUM_CODES = 1 << CODE_W;

   typedef enum logic {
      LAYOUT_TILE = 1'b0,
      LAYOUT_CHAN = 1'b1
   } evb_layout_e;
endpackage

// File: rtl/evb_decode.sv
module evb_decode
   import evb_pkg::*;
#(
   parameter int          ADDR_W   = 12,
   parameter int          NUM_CTR  = 4,
   parameter evb_layout_e LAYOUT   = LAYOUT_TILE,
   parameter int          T_CTL    = 'hA8,
   parameter int          T_DOFF   = 'h4,
   parameter int          T_STRIDE = 'h8,
   parameter int          C_CTL    = 'h234,
   parameter int          C_DATA   = 'h240,
   parameter int          C_STRIDE = 'hC
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_CTR-1:0]  ctl_hit,
   output logic [NUM_CTR-1:0]  data_hit
);
   for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
      if (LAYOUT == LAYOUT_TILE) begin : g_tile
         localparam int CA = T_CTL + n * T_STRIDE;
         localparam int DA = T_CTL + T_DOFF + n * T_STRIDE;
         assign ctl_hit[n]  = (addr == ADDR_W'(CA));
         assign data_hit[n] = (addr == ADDR_W'(DA));
      end else begin : g_chan
         localparam int DA = C_DATA + n * C_STRIDE;
         assign ctl_hit[n]  = (addr == ADDR_W'(C_CTL));
         assign data_hit[n] = (addr == ADDR_W'(DA));
      end
   end

   AST_ONE_DATA_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(data_hit)) else $error("two data registers share an address"); // R5

   AST_CTL_DATA_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !((|ctl_hit) && (|data_hit))) else $error("control and data overlap"); // R6
endmodule

// File: rtl/evb_ctl_bank.sv
module evb_ctl_bank
   import evb_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          NUM_CTR   = 4,
   parameter evb_layout_e LAYOUT    = LAYOUT_TILE,
   parameter int          CODE_LIM  = 24,
   parameter int          FLD_LSB   = 3,
   parameter int          FLD_STEP  = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wen,
   input  logic [NUM_CTR-1:0]             ctl_hit,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NUM_CTR-1:0][CODE_W-1:0] codes
);
   for (genvar n = 0; n < NUM_CTR; n++) begin : g_fld
      localparam int POS = FLD_LSB + n * FLD_STEP;
      logic [CODE_W-1:0] field;
      logic              take;

      assign field = wdata[POS +: CODE_W];
      assign take  = wen && ctl_hit[n] && (int'(field) < CODE_LIM);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    codes[n] <= '0;
         else if (take) codes[n] <= field;
      end

      AST_BAD_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (wen && ctl_hit[n] && (int'(field) >= CODE_LIM)) |=> $stable(codes[n]))
         else $error("out-of-range code accepted"); // R8

      AST_NO_STRAY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
         !(wen && ctl_hit[n]) |=> $stable(codes[n]))
         else $error("code changed without a control write"); // R9
   end
endmodule

// File: rtl/evb_counter.sv
module evb_counter
   import evb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CODE_W-1:0]     code,
   input  logic [NUM_CODES-1:0]  evt,
   input  logic                  load,
   input  logic [DATA_W-1:0]     load_val,
   output logic [DATA_W-1:0]     count
);
   logic bump;

   assign bump = (code != '0) && evt[code];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (bump) count <= count + DATA_W'(1);
   end

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0 && !load) |=> $stable(count)) else $error("stopped counter moved"); // R3

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val)) else $error("load lost"); // R7

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && code != '0 && evt[code]) |=> count == $past(count) + DATA_W'(1))
      else $error("increment wrong"); // R2

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && bump && count == '1) |=> count == '0) else $error("wrap wrong"); // R4
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
   import evb_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter int          DATA_W  = 32,
   parameter int          NUM_CTR = 4,
   parameter evb_layout_e LAYOUT  = LAYOUT_TILE,
   parameter int          T_LIMIT = 'h18,
   parameter int          C_LIMIT = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ren,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [31:0]       evt_strobe
);
   localparam bit IS_TILE  = (LAYOUT == LAYOUT_TILE);
   localparam int FLD_LSB  = IS_TILE ? 3 : 1;
   localparam int FLD_STEP = IS_TILE ? 0 : 8;
   localparam int CODE_LIM = IS_TILE ? T_LIMIT : C_LIMIT;

   initial begin : elab_checks
      assert (NUM_CODES == 32) else $error("strobe vector must match code space");
      assert (NUM_CTR >= 1 && NUM_CTR <= 4) else $error("NUM_CTR out of range");
      assert (FLD_LSB + (NUM_CTR - 1) * FLD_STEP + CODE_W <= DATA_W)
         else $error("code field outside control word");
      assert (CODE_LIM >= 1 && CODE_LIM <= NUM_CODES) else $error("bad code limit");
   end

   logic [NUM_CTR-1:0]             ctl_hit, data_hit;
   logic [NUM_CTR-1:0][CODE_W-1:0] codes;
   logic [NUM_CTR-1:0][DATA_W-1:0] counts;
   logic [DATA_W-1:0]              rd_next;

   evb_decode #(
      .ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR), .LAYOUT(LAYOUT)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr),
      .ctl_hit(ctl_hit), .data_hit(data_hit)
   );

   evb_ctl_bank #(
      .DATA_W(DATA_W), .NUM_CTR(NUM_CTR), .LAYOUT(LAYOUT),
      .CODE_LIM(CODE_LIM), .FLD_LSB(FLD_LSB), .FLD_STEP(FLD_STEP)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .wen(bus_wen), .ctl_hit(ctl_hit),
      .wdata(bus_wdata), .codes(codes)
   );

   for (genvar n = 0; n < NUM_CTR; n++) begin : g_cnt
      evb_counter #(.DATA_W(DATA_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .code(codes[n]), .evt(evt_strobe),
         .load(bus_wen && data_hit[n]), .load_val(bus_wdata),
         .count(counts[n])
      );
   end

   always_comb begin
      rd_next = '0;
      for (int n = 0; n < NUM_CTR; n++) begin
         if (data_hit[n]) rd_next |= counts[n];
         if (ctl_hit[n])  rd_next |= DATA_W'(codes[n]) << (FLD_LSB + n * FLD_STEP);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bus_rdata <= '0;
      else if (bus_ren) bus_rdata <= rd_next;
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ren |=> $stable(bus_rdata)) else $error("read data moved unprompted"); // R10

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ren && !(|ctl_hit) && !(|data_hit)) |=> bus_rdata == '0)
      else $error("unmapped read not zero"); // R9
endmodule

// File: tb/evt_ctr_bank_test.sv
module evt_ctr_bank_test;
   import evb_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wen = 1'b0, ren = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0, evt = '0;
   logic [31:0] rd_t, rd_c;

   always #4 clk = ~clk;

   evt_ctr_bank #(.LAYOUT(LAYOUT_TILE)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata),
      .bus_ren(ren), .bus_rdata(rd_t), .evt_strobe(evt));

   evt_ctr_bank #(.LAYOUT(LAYOUT_CHAN)) uut_ch (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen), .bus_wdata(wdata),
      .bus_ren(ren), .bus_rdata(rd_c), .evt_strobe(evt));

   int          checks = 0, fails = 0;
   logic [31:0] m_cnt [2][4];
   logic [4:0]  m_code[2][4];
   logic [31:0] last_t = '0, last_c = '0;

   function automatic logic [11:0] ctl_a(int l, int n);
      return (l == 0) ? 12'(32'hA8 + 8 * n) : 12'h234;
   endfunction

   function automatic logic [11:0] dat_a(int l, int n);
      return (l == 0) ? 12'(32'hAC + 8 * n) : 12'(32'h240 + 12 * n);
   endfunction

   function automatic logic [31:0] rd_exp(int l, logic [11:0] a);
      logic [31:0] r = '0;
      for (int n = 0; n < 4; n++) begin
         if (a == dat_a(l, n)) r = m_cnt[l][n];
         if (a == ctl_a(l, n))
            r |= (l == 0) ? (32'(m_code[l][n]) << 3) : (32'(m_code[l][n]) << (8 * n + 1));
      end
      return r;
   endfunction

   task automatic model_edge(logic w, logic [11:0] a, logic [31:0] d, logic [31:0] e);
      for (int l = 0; l < 2; l++) begin
         for (int n = 0; n < 4; n++) begin
            logic [4:0] f;
            if (w && a == dat_a(l, n)) m_cnt[l][n] = d;
            else if (m_code[l][n] != 0 && e[m_code[l][n]]) m_cnt[l][n] = m_cnt[l][n] + 1;
            f = (l == 0) ? d[7:3] : d[8 * n + 1 +: 5];
            if (w && a == ctl_a(l, n) && int'(f) < ((l == 0) ? 24 : 16)) m_code[l][n] = f;
         end
      end
   endtask

   task automatic check(string tag, int l, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s layout=%0d actual=%h expected=%h", tag, l, act, exp);
      end
   endtask

   task automatic step(string tag, logic w, logic [11:0] a, logic [31:0] d,
                       logic r, logic [31:0] e);
      logic [31:0] et, ec;
      @(negedge clk);
      wen = w; addr = a; wdata = d; ren = r; evt = e;
      et = rd_exp(0, a);
      ec = rd_exp(1, a);
      model_edge(w, a, d, e);
      @(posedge clk);
      #1;
      if (r) begin
         check(tag, 0, rd_t, et);
         check(tag, 1, rd_c, ec);
         last_t = et;
         last_c = ec;
      end
   endtask

   task automatic read_all(string tag);
      for (int l = 0; l < 2; l++)
         for (int n = 0; n < 4; n++) begin
            step(tag, 1'b0, ctl_a(l, n), '0, 1'b1, '0);
            step(tag, 1'b0, dat_a(l, n), '0, 1'b1, '0);
         end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      for (int l = 0; l < 2; l++)
         for (int n = 0; n < 4; n++) begin
            m_cnt[l][n] = '0;
            m_code[l][n] = '0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: everything zero after reset
      read_all("R1");

      // R5: tile control at 0xA8+8n, code in [7:3]; R9: spare bits read zero
      step("R5", 1'b1, 12'hB0, 32'hFFFF_FF7F, 1'b0, '0);   // ctr1 code 0x0F
      step("R9", 1'b0, 12'hB0, '0, 1'b1, '0);
      step("R5", 1'b1, 12'hA8, 32'h0000_0068, 1'b0, '0);   // ctr0 code 0x0D
      // R6: shared control word, byte n bits [8n+5:8n+1]
      step("R6", 1'b1, 12'h234,
           32'h8000_00C1 | (32'h01 << 1) | (32'h0B << 9) | (32'h0D << 17) | (32'h0F << 25),
           1'b0, '0);
      step("R6", 1'b0, 12'h234, '0, 1'b1, '0);
      // R10: no read strobe, output holds
      step("R10", 1'b0, 12'hAC, '0, 1'b0, 32'hFFFF_FFFF);
      check("R10", 0, rd_t, last_t);
      check("R10", 1, rd_c, last_c);

      // R2: counting on selected strobes
      for (int i = 0; i < 6; i++) step("R2", 1'b0, 12'h0, '0, 1'b0, 32'h0000_A002 << (i % 2));
      read_all("R2");

      // R7: data write beats same-cycle increment
      step("R7", 1'b1, 12'hB4, 32'h0000_1000, 1'b0, 32'h0000_8000);
      step("R7", 1'b1, 12'h240, 32'h0000_0055, 1'b0, 32'h0000_0002);
      step("R7", 1'b0, 12'hB4, '0, 1'b1, '0);
      step("R7", 1'b0, 12'h240, '0, 1'b1, '0);

      // R4: wrap to zero
      step("R4", 1'b1, 12'hB4, 32'hFFFF_FFFE, 1'b0, '0);
      step("R4", 1'b1, 12'h240, 32'hFFFF_FFFF, 1'b0, '0);
      step("R4", 1'b0, 12'h0, '0, 1'b0, 32'h0000_8002);
      step("R4", 1'b0, 12'h0, '0, 1'b0, 32'h0000_8000);
      step("R4", 1'b0, 12'hB4, '0, 1'b1, '0);
      step("R4", 1'b0, 12'h240, '0, 1'b1, '0);

      // R3: code zero stops counting
      step("R3", 1'b1, 12'hB0, 32'h0000_0007, 1'b0, 32'h0000_8000);
      for (int i = 0; i < 4; i++) step("R3", 1'b0, 12'h0, '0, 1'b0, 32'hFFFF_FFFF);
      step("R3", 1'b0, 12'hB4, '0, 1'b1, '0);

      // R8: out-of-range codes discarded
      step("R8", 1'b1, 12'hA8, 32'h0000_00C0, 1'b0, '0);   // 0x18 in tile
      step("R8", 1'b0, 12'hA8, '0, 1'b1, '0);
      step("R8", 1'b1, 12'h234, (32'h03 << 1) | (32'h10 << 17), 1'b0, '0);
      step("R8", 1'b0, 12'h234, '0, 1'b1, '0);

      // R9: unmapped addresses
      step("R9", 1'b1, 12'h100, 32'hDEAD_BEEF, 1'b0, '0);
      step("R9", 1'b0, 12'h100, '0, 1'b1, '0);
      step("R9", 1'b0, 12'hAA, '0, 1'b1, '0);

      // R2: random traffic
      for (int i = 0; i < 600; i++) begin
         int          op = $urandom % 4;
         int          l = $urandom % 2;
         int          n = $urandom % 4;
         logic [31:0] e = $urandom & $urandom;
         logic [31:0] d = $urandom;
         case (op)
            0: step("R2", 1'b1, ctl_a(l, n), d, 1'b0, e);
            1: step("R2", 1'b1, dat_a(l, n), (d[0] ? 32'hFFFF_FFF0 | d[3:0] : d), 1'b0, e);
            2: step("R2", 1'b0, (d[1] ? ctl_a(l, n) : dat_a(l, n)), '0, 1'b1, e);
            default: step("R2", 1'b0, 12'(d), '0, 1'b1, e);
         endcase
      end
      read_all("R2");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule